// File: doc/BRIEF.md
# Prioritized Channel-Mapped Interrupt Controller

This block gathers a parameterized number of system interrupt inputs and presents them to two host lines: a fast line and a normal line. Each input is first synchronized. It is then qualified by its own detection mode: active-high level, active-low level, rising edge or falling edge. A detected event sets the input's pending status bit. Each pending input that is also enabled competes for its host line according to a 5-bit channel number stored per input.

Channels 0 and 1 belong to the fast line and channels 2 to 31 to the normal line. On each line, the lowest channel number wins; within a channel, the lowest input number wins. Each host output carries a valid flag and the winning input number. Both are registered. A line is gated by a global enable and by its own host enable.

Software reaches the block through a word-addressed register port with single-cycle write and read strobes. Read data appears one cycle after the read strobe. Word addresses (8 bits):

| Address | Register | Access |
|---|---|---|
| 0x00 | global enable, bit 0 | read/write |
| 0x01 | host enables, bit 0 = fast, bit 1 = normal | read only |
| 0x02 | indexed enable set | write only |
| 0x03 | indexed enable clear | write only |
| 0x04 | indexed status clear | write only |
| 0x05 | indexed host-enable set | write only |
| 0x06 | indexed host-enable clear | write only |
| 0x10+g | enables of group g | read only |
| 0x18+g | bulk enable clear of group g | write only |
| 0x20+g | pending status of group g | read only |
| 0x28+g | bulk status clear of group g | write only |
| 0x30+g | polarity bits of group g | read/write |
| 0x38+g | type bits of group g | read/write |
| 0x40+w | channel map word w | read/write |

Group g covers inputs 32g to 32g+31, and input 32g+b sits at bit b.

Top module: `prio_chan_intc`

## Requirements
- R1: Detection mode per input is {type, polarity}. 00 is level active-low, 01 is level active-high, 10 is falling edge and 11 is rising edge. An edge input sets status only on the selected transition, seen after a two-flop synchronizer.
- R2: An edge event stays pending after the input returns. A level input's status bit stays set while the input is active, even when a clear is written in the same or a later cycle.
- R3: Writing an input number below NUM_IN to 0x02 sets that input's enable, and writing it to 0x03 clears it. Numbers of NUM_IN or more change nothing.
- R4: Writing an input number to 0x04 clears that input's pending status.
- R5: For an input in group g at bit b, writing a word with bit b = 1 to 0x18+g clears its enable, and writing such a word to 0x28+g clears its status. Inputs whose bit is 0 are untouched.
- R6: In channel map word w, input 4w+k takes bits 8k+4:8k. A read of the word returns each 5-bit channel zero-extended in its byte.
- R7: On a host line, the pending enabled input with the lowest channel wins. Between equal channels, the lowest input number wins.
- R8: Channels 0 and 1 feed only the fast line (fiq_*), and channels 2 to 31 feed only the normal line (irq_*).
- R9: A host line is valid only while the global enable (0x00 bit 0) is 1 and its own host enable is set. Writing 0 (fast) or 1 (normal) to 0x05 sets a host enable, and writing it to 0x06 clears it.
- R10: After reset the following are all 0: every enable, host enable, global enable, polarity bit, type bit and channel byte, and both valid outputs.
- R11: Read data is registered and appears the cycle after reg_rd. The write-only registers (0x02 to 0x06, 0x18+g, 0x28+g) read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| sys_irq | input | NUM_IN | system interrupt inputs |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_addr | input | 8 | word address |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, one cycle after reg_rd |
| fiq_valid | output | 1 | fast line asserted |
| fiq_id | output | $clog2(NUM_IN) | winning input on the fast line |
| irq_valid | output | 1 | normal line asserted |
| irq_id | output | $clog2(NUM_IN) | winning input on the normal line |

## Verification
The hardest case to reach from the ports is a tie between inputs in different groups on the same channel, while a third input on another line competes at the same time. The bench maps several inputs onto shared channels and then drives patterns that mix fast-line and normal-line sources. Both winners are checked in the same cycle.

Edge modes need the input to move after the mode is set. For this reason, a falling-edge input is reconfigured while it sits low, and its rising transition is shown to leave status clear. A level input is cleared while still active, to show that its status persists.

// File: rtl/pcintc_pkg.sv
package pcintc_pkg;

    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int CHAN_W      = 5;
    localparam int GRP_BITS    = 32;
    localparam int CH_PER_WORD = 4;
    localparam int NUM_HOSTS   = 2;

    // highest channel that belongs to the fast host line
    localparam logic [CHAN_W-1:0] FAST_TOP = 5'd1;

    localparam logic [ADDR_W-1:0] A_GLB      = 8'h00;
    localparam logic [ADDR_W-1:0] A_HEN      = 8'h01;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 8'h02;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 8'h03;
    localparam logic [ADDR_W-1:0] A_ST_CLR   = 8'h04;
    localparam logic [ADDR_W-1:0] A_HEN_SET  = 8'h05;
    localparam logic [ADDR_W-1:0] A_HEN_CLR  = 8'h06;
    localparam logic [ADDR_W-1:0] A_EN_GRP   = 8'h10;
    localparam logic [ADDR_W-1:0] A_ENC_GRP  = 8'h18;
    localparam logic [ADDR_W-1:0] A_ST_GRP   = 8'h20;
    localparam logic [ADDR_W-1:0] A_STC_GRP  = 8'h28;
    localparam logic [ADDR_W-1:0] A_POL_GRP  = 8'h30;
    localparam logic [ADDR_W-1:0] A_TYP_GRP  = 8'h38;
    localparam logic [ADDR_W-1:0] A_MAP_WORD = 8'h40;

    typedef enum logic [1:0] {
        DET_LVL_LOW  = 2'b00,
        DET_LVL_HIGH = 2'b01,
        DET_EDGE_FALL = 2'b10,
        DET_EDGE_RISE = 2'b11
    } det_mode_e;

    function automatic det_mode_e mode_of(input logic typ, input logic pol);
        return det_mode_e'({typ, pol});
    endfunction

    function automatic logic host_takes(input int host, input logic [CHAN_W-1:0] ch);
        return (host == 0) ? (ch <= FAST_TOP) : (ch > FAST_TOP);
    endfunction

endpackage

// File: rtl/pcintc_detect.sv
module pcintc_detect
    import pcintc_pkg::*;
#(
    parameter int NUM_IN = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] sys_in,
    input  logic [NUM_IN-1:0] pol,
    input  logic [NUM_IN-1:0] typ,
    output logic [NUM_IN-1:0] det
);

    logic [NUM_IN-1:0] sync_a, sync_b, sync_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a    <= '0;
            sync_b    <= '0;
            sync_prev <= '0;
        end else begin
            sync_a    <= sys_in;
            sync_b    <= sync_a;
            sync_prev <= sync_b;
        end
    end

    for (genvar i = 0; i < NUM_IN; i++) begin : g_bit
        det_mode_e mode;
        assign mode = mode_of(typ[i], pol[i]);
        assign det[i] = (mode == DET_EDGE_RISE) ? ( sync_b[i] & ~sync_prev[i]) :
                        (mode == DET_EDGE_FALL) ? (~sync_b[i] &  sync_prev[i]) :
                        (mode == DET_LVL_HIGH)  ?   sync_b[i] :
                                                   ~sync_b[i];
    end

endmodule

// File: rtl/pcintc_regs.sv
module pcintc_regs
    import pcintc_pkg::*;
#(
    parameter int NUM_IN = 40
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr,
    input  logic                          rd,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    input  logic [NUM_IN-1:0]             det,
    output logic [NUM_IN-1:0]             enable,
    output logic [NUM_IN-1:0]             status,
    output logic [NUM_IN-1:0]             pol,
    output logic [NUM_IN-1:0]             typ,
    output logic [NUM_IN-1:0][CHAN_W-1:0] chan,
    output logic                          glb_en,
    output logic [NUM_HOSTS-1:0]          host_en
);

    localparam int NGRP  = (NUM_IN + GRP_BITS - 1) / GRP_BITS;
    localparam int NWORD = (NUM_IN + CH_PER_WORD - 1) / CH_PER_WORD;

    logic [NUM_IN-1:0]             en_nx, st_nx, pol_nx, typ_nx;
    logic [NUM_IN-1:0][CHAN_W-1:0] chan_nx;
    logic [NUM_HOSTS-1:0]          hen_nx;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        localparam int GRP = i / GRP_BITS;
        localparam int BIT = i % GRP_BITS;
        localparam int WRD = i / CH_PER_WORD;
        localparam int BYT = i % CH_PER_WORD;
        localparam logic [ADDR_W-1:0] A_ENC = A_ENC_GRP  + 8'(GRP);
        localparam logic [ADDR_W-1:0] A_STC = A_STC_GRP  + 8'(GRP);
        localparam logic [ADDR_W-1:0] A_POL = A_POL_GRP  + 8'(GRP);
        localparam logic [ADDR_W-1:0] A_TYP = A_TYP_GRP  + 8'(GRP);
        localparam logic [ADDR_W-1:0] A_MAP = A_MAP_WORD + 8'(WRD);

        logic hit_idx, en_set, en_clr, st_clr;
        assign hit_idx = (wdata == DATA_W'(i));
        assign en_set  = wr && (addr == A_EN_SET) && hit_idx;
        assign en_clr  = wr && (((addr == A_EN_CLR) && hit_idx) ||
                                ((addr == A_ENC) && wdata[BIT]));
        assign st_clr  = wr && (((addr == A_ST_CLR) && hit_idx) ||
                                ((addr == A_STC) && wdata[BIT]));

        assign en_nx[i]   = en_set | (enable[i] & ~en_clr);
        // a detection in the same cycle outranks a clear
        assign st_nx[i]   = det[i] | (status[i] & ~st_clr);
        assign pol_nx[i]  = (wr && addr == A_POL) ? wdata[BIT] : pol[i];
        assign typ_nx[i]  = (wr && addr == A_TYP) ? wdata[BIT] : typ[i];
        assign chan_nx[i] = (wr && addr == A_MAP) ? wdata[BYT*8 +: CHAN_W] : chan[i];
    end

    for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
        logic hit_h;
        assign hit_h = (wdata == DATA_W'(h));
        assign hen_nx[h] = (wr && addr == A_HEN_SET && hit_h) |
                           (host_en[h] & ~(wr && addr == A_HEN_CLR && hit_h));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable  <= '0;
            status  <= '0;
            pol     <= '0;
            typ     <= '0;
            chan    <= '0;
            host_en <= '0;
            glb_en  <= 1'b0;
        end else begin
            enable  <= en_nx;
            status  <= st_nx;
            pol     <= pol_nx;
            typ     <= typ_nx;
            chan    <= chan_nx;
            host_en <= hen_nx;
            if (wr && addr == A_GLB) glb_en <= wdata[0];
        end
    end

    // read path
    logic [NGRP*GRP_BITS-1:0]           en_pad, st_pad, pol_pad, typ_pad;
    logic [NWORD*CH_PER_WORD-1:0][7:0]  map_bytes;
    logic [DATA_W-1:0]                  rval;

    always_comb begin
        en_pad  = '0;
        st_pad  = '0;
        pol_pad = '0;
        typ_pad = '0;
        en_pad[NUM_IN-1:0]  = enable;
        st_pad[NUM_IN-1:0]  = status;
        pol_pad[NUM_IN-1:0] = pol;
        typ_pad[NUM_IN-1:0] = typ;
        map_bytes = '0;
        for (int i = 0; i < NUM_IN; i++) map_bytes[i] = {3'b000, chan[i]};
    end

    always_comb begin
        rval = '0;
        if (addr == A_GLB) rval[0] = glb_en;
        if (addr == A_HEN) rval[NUM_HOSTS-1:0] = host_en;
        for (int g = 0; g < NGRP; g++) begin
            if (addr == A_EN_GRP  + 8'(g)) rval = en_pad[g*GRP_BITS +: GRP_BITS];
            if (addr == A_ST_GRP  + 8'(g)) rval = st_pad[g*GRP_BITS +: GRP_BITS];
            if (addr == A_POL_GRP + 8'(g)) rval = pol_pad[g*GRP_BITS +: GRP_BITS];
            if (addr == A_TYP_GRP + 8'(g)) rval = typ_pad[g*GRP_BITS +: GRP_BITS];
        end
        for (int w = 0; w < NWORD; w++) begin
            if (addr == A_MAP_WORD + 8'(w)) rval = map_bytes[w*CH_PER_WORD +: CH_PER_WORD];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd ? rval : '0;
    end

endmodule

// File: rtl/pcintc_arb.sv
module pcintc_arb
    import pcintc_pkg::*;
#(
    parameter int NUM_IN = 40,
    parameter int HOST   = 0,
    localparam int ID_W  = $clog2(NUM_IN)
) (
    input  logic [NUM_IN-1:0]             pend,
    input  logic [NUM_IN-1:0][CHAN_W-1:0] chan,
    output logic                          found,
    output logic [ID_W-1:0]               win_id
);

    logic [CHAN_W-1:0] best_ch;

    // ascending scan; strict compare keeps the lowest input on a channel tie
    always_comb begin
        found   = 1'b0;
        best_ch = '1;
        win_id  = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (pend[i] && host_takes(HOST, chan[i]) && (!found || chan[i] < best_ch)) begin
                found   = 1'b1;
                best_ch = chan[i];
                win_id  = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_chan_intc.sv
module prio_chan_intc
    import pcintc_pkg::*;
#(
    parameter int NUM_IN = 40,
    localparam int ID_W  = $clog2(NUM_IN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] sys_irq,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              fiq_valid,
    output logic [ID_W-1:0]   fiq_id,
    output logic              irq_valid,
    output logic [ID_W-1:0]   irq_id
);

    logic [NUM_IN-1:0]             det, enable, status, pol, typ, pend;
    logic [NUM_IN-1:0][CHAN_W-1:0] chan;
    logic                          glb_en;
    logic [NUM_HOSTS-1:0]          host_en;
    logic [NUM_HOSTS-1:0]          found;
    logic [ID_W-1:0]               win_id [NUM_HOSTS];
    logic [NUM_HOSTS-1:0]          valid_q;
    logic [ID_W-1:0]               id_q   [NUM_HOSTS];

    pcintc_detect #(.NUM_IN(NUM_IN)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .sys_in (sys_irq),
        .pol    (pol),
        .typ    (typ),
        .det    (det)
    );

    pcintc_regs #(.NUM_IN(NUM_IN)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .rd      (reg_rd),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .det     (det),
        .enable  (enable),
        .status  (status),
        .pol     (pol),
        .typ     (typ),
        .chan    (chan),
        .glb_en  (glb_en),
        .host_en (host_en)
    );

    assign pend = status & enable;

    for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_arb
        pcintc_arb #(.NUM_IN(NUM_IN), .HOST(h)) u_arb (
            .pend   (pend),
            .chan   (chan),
            .found  (found[h]),
            .win_id (win_id[h])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int h = 0; h < NUM_HOSTS; h++) id_q[h] <= '0;
        end else begin
            for (int h = 0; h < NUM_HOSTS; h++) begin
                valid_q[h] <= glb_en & host_en[h] & found[h];
                id_q[h]    <= win_id[h];
            end
        end
    end

    assign fiq_valid = valid_q[0];
    assign fiq_id    = id_q[0];
    assign irq_valid = valid_q[1];
    assign irq_id    = id_q[1];

endmodule

// File: rtl/prio_chan_intc_chk.sv
module prio_chan_intc_chk
    import pcintc_pkg::*;
#(
    parameter int NUM_IN = 40,
    localparam int ID_W  = $clog2(NUM_IN)
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [7:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              glb_en,
    input logic [1:0]        host_en,
    input logic [NUM_IN-1:0] enable,
    input logic              fiq_valid,
    input logic [ID_W-1:0]   fiq_id,
    input logic              irq_valid,
    input logic [ID_W-1:0]   irq_id
);

    AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (rst)
        $past(!glb_en) |-> (!fiq_valid && !irq_valid)); // R9

    AST_FAST_HOST_GATE: assert property (@(posedge clk) disable iff (rst)
        $past(!host_en[0]) |-> !fiq_valid); // R9

    AST_NORM_HOST_GATE: assert property (@(posedge clk) disable iff (rst)
        $past(!host_en[1]) |-> !irq_valid); // R9

    AST_EN_IDX_SET: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_EN_SET && reg_wdata < 32'(NUM_IN))
        |=> enable[$past(reg_wdata[ID_W-1:0])]); // R3

    AST_EN_IDX_CLR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_EN_CLR && reg_wdata < 32'(NUM_IN))
        |=> !enable[$past(reg_wdata[ID_W-1:0])]); // R3

    AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (fiq_valid || irq_valid) |-> (32'(fiq_id) < NUM_IN && 32'(irq_id) < NUM_IN)); // R7

endmodule

bind prio_chan_intc prio_chan_intc_chk #(.NUM_IN(NUM_IN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .glb_en    (glb_en),
    .host_en   (host_en),
    .enable    (enable),
    .fiq_valid (fiq_valid),
    .fiq_id    (fiq_id),
    .irq_valid (irq_valid),
    .irq_id    (irq_id)
);

// File: tb/prio_chan_intc_tb.sv
module prio_chan_intc_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N    = 40;
    localparam int ID_W = $clog2(N);

    logic            clk = 1'b0;
    logic            rst;
    logic [N-1:0]    sys_irq;
    logic            reg_wr, reg_rd;
    logic [7:0]      reg_addr;
    logic [31:0]     reg_wdata;
    logic [31:0]     reg_rdata;
    logic            fiq_valid, irq_valid;
    logic [ID_W-1:0] fiq_id, irq_id;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_chan_intc #(.NUM_IN(N)) u_dut (
        .clk(clk), .rst(rst), .sys_irq(sys_irq),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fiq_valid(fiq_valid), .fiq_id(fiq_id),
        .irq_valid(irq_valid), .irq_id(irq_id)
    );

    typedef struct packed {
        logic [39:0] pat;
        logic        fv;
        logic [5:0]  fid;
        logic        iv;
        logic [5:0]  iid;
    } vec_t;

    // R7 / R8 table: channels 0->5, 3->1, 7->0, 12->0, 20->2, 33->2, 39->31, others 15
    localparam vec_t VEC [11] = '{
        '{40'h00_0010_0000, 1'b0, 6'd0,  1'b1, 6'd20},
        '{40'h02_0010_0000, 1'b0, 6'd0,  1'b1, 6'd20},
        '{40'h82_0000_0000, 1'b0, 6'd0,  1'b1, 6'd33},
        '{40'h80_0000_0001, 1'b0, 6'd0,  1'b1, 6'd0},
        '{40'h00_0000_1088, 1'b1, 6'd7,  1'b0, 6'd0},
        '{40'h00_0000_0009, 1'b1, 6'd3,  1'b1, 6'd0},
        '{40'h80_0000_1008, 1'b1, 6'd12, 1'b1, 6'd39},
        '{40'h00_0000_0020, 1'b0, 6'd0,  1'b1, 6'd5},
        '{40'h00_0000_0060, 1'b0, 6'd0,  1'b1, 6'd5},
        '{40'h00_0000_0021, 1'b0, 6'd0,  1'b1, 6'd0},
        '{40'h00_0000_0000, 1'b0, 6'd0,  1'b0, 6'd0}
    };

    function automatic logic [4:0] chan_of(input int i);
        case (i)
            0:  return 5'd5;
            3:  return 5'd1;
            7:  return 5'd0;
            12: return 5'd0;
            20: return 5'd2;
            33: return 5'd2;
            39: return 5'd31;
            default: return 5'd15;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic check_hosts(input string req, input logic fv, input logic [5:0] fid,
                               input logic iv, input logic [5:0] iid);
        logic [31:0] act, exp;
        act = {16'h0, 7'h0, fiq_valid, fv ? 8'(fiq_id) : 8'h0};
        act = {act[15:0], 7'h0, irq_valid, iv ? 8'(irq_id) : 8'h0};
        exp = {7'h0, fv, 2'b00, fid, 7'h0, iv, 2'b00, iid};
        check(req, act, exp);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic clear_all_status();
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h29, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1; sys_irq = '0; reg_wr = 1'b0; reg_rd = 1'b0;
        reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check_hosts("R10 outputs after reset", 1'b0, 6'd0, 1'b0, 6'd0);
        rd(8'h10, d); check("R10 enables group 0", d, 32'h0);
        rd(8'h40, d); check("R10 channel word 0", d, 32'h0);
        rd(8'h30, d); check("R10 polarity group 0", d, 32'h0);
        rd(8'h00, d); check("R10 global enable", d, 32'h0);
        rd(8'h01, d); check("R10 host enables", d, 32'h0);

        // setup: all active-high level, all enabled, channel map, hosts on
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h31, 32'h0000_00FF);
        clear_all_status();
        settle();
        rd(8'h20, d); check("R5 bulk status clear group 0", d, 32'h0);
        for (int i = 0; i < N; i++) wr(8'h02, 32'(i));
        rd(8'h11, d); check("R3 indexed enable set group 1", d, 32'h0000_00FF);
        for (int w = 0; w < N/4; w++) begin
            logic [31:0] word;
            for (int k = 0; k < 4; k++) word[8*k +: 8] = {3'b000, chan_of(4*w + k)};
            wr(8'h40 + 8'(w), word);
        end
        rd(8'h40, d); check("R6 channel word 0 byte order", d, 32'h010F_0F05);
        rd(8'h41, d); check("R6 channel word 1 byte order", d, 32'h000F_0F0F);
        wr(8'h00, 32'h1);
        wr(8'h05, 32'h0);
        wr(8'h05, 32'h1);
        rd(8'h01, d); check("R9 host enables set", d, 32'h3);

        // R7 / R8 vector table
        foreach (VEC[v]) begin
            sys_irq = VEC[v].pat;
            settle();
            check_hosts($sformatf("R7 R8 vector %0d", v), VEC[v].fv, VEC[v].fid,
                        VEC[v].iv, VEC[v].iid);
            sys_irq = '0;
            settle();
            clear_all_status();
            settle();
        end

        // R9 global gate
        sys_irq[20] = 1'b1;
        settle();
        wr(8'h00, 32'h0);
        settle();
        check_hosts("R9 global enable off", 1'b0, 6'd0, 1'b0, 6'd0);
        wr(8'h00, 32'h1);
        settle();
        check_hosts("R9 global enable on", 1'b0, 6'd0, 1'b1, 6'd20);

        // R9 per-host gate
        sys_irq[7] = 1'b1;
        settle();
        wr(8'h06, 32'h1);
        settle();
        check_hosts("R9 normal host cleared", 1'b1, 6'd7, 1'b0, 6'd0);
        wr(8'h05, 32'h1);
        settle();
        check_hosts("R9 normal host restored", 1'b1, 6'd7, 1'b1, 6'd20);

        // R2 level persists through clear; R4 indexed clear
        sys_irq[7] = 1'b0;
        settle();
        wr(8'h04, 32'd7);
        wr(8'h04, 32'd20);
        settle();
        check_hosts("R2 level held, R4 cleared input 7", 1'b0, 6'd0, 1'b1, 6'd20);
        sys_irq[20] = 1'b0;
        settle();
        check_hosts("R2 level status latched after release", 1'b0, 6'd0, 1'b1, 6'd20);
        wr(8'h04, 32'd20);
        settle();
        check_hosts("R4 indexed status clear", 1'b0, 6'd0, 1'b0, 6'd0);
        rd(8'h20, d); check("R4 status group 0 empty", d, 32'h0);

        // R1 rising edge on input 20
        wr(8'h38, 32'h0010_0000);
        clear_all_status();
        @(negedge clk); sys_irq[20] = 1'b1;
        repeat (2) @(negedge clk); sys_irq[20] = 1'b0;
        settle();
        check_hosts("R1 R2 rising edge held", 1'b0, 6'd0, 1'b1, 6'd20);
        wr(8'h04, 32'd20);
        settle();
        check_hosts("R4 edge status cleared", 1'b0, 6'd0, 1'b0, 6'd0);
        sys_irq[20] = 1'b1;
        settle();
        wr(8'h04, 32'd20);
        settle();
        check_hosts("R1 edge mode ignores held level", 1'b0, 6'd0, 1'b0, 6'd0);
        sys_irq[20] = 1'b0;
        settle();

        // R1 falling edge on input 33
        wr(8'h39, 32'h0000_0002);
        wr(8'h31, 32'h0000_00FD);
        clear_all_status();
        settle();
        sys_irq[33] = 1'b1;
        settle();
        check_hosts("R1 falling mode ignores rise", 1'b0, 6'd0, 1'b0, 6'd0);
        sys_irq[33] = 1'b0;
        settle();
        check_hosts("R1 falling edge detected", 1'b0, 6'd0, 1'b1, 6'd33);
        wr(8'h29, 32'h0000_0001);
        settle();
        check_hosts("R5 bulk clear other bit leaves 33", 1'b0, 6'd0, 1'b1, 6'd33);
        wr(8'h29, 32'h0000_0002);
        settle();
        check_hosts("R5 bulk status clear bit 1", 1'b0, 6'd0, 1'b0, 6'd0);

        // R3 out of range and indexed clear; R5 bulk enable clear
        wr(8'h03, 32'd40);
        rd(8'h11, d); check("R3 out-of-range index ignored", d, 32'h0000_00FF);
        wr(8'h03, 32'd39);
        rd(8'h11, d); check("R3 indexed enable clear", d, 32'h0000_007F);
        wr(8'h18, 32'h0000_0001);
        rd(8'h10, d); check("R5 bulk enable clear", d, 32'hFFFF_FFFE);

        // R11 write-only registers read 0
        rd(8'h02, d); check("R11 indexed register reads 0", d, 32'h0);
        rd(8'h28, d); check("R11 bulk clear register reads 0", d, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule